// File: doc/BRIEF.md
# Spread-Spectrum Delta Profile Sequencer

This block produces the fractional offset word that steers a fractional-N PLL when the clock is spread. The waveform is kept compactly: a 6-bit unsigned starting value and a table of twelve 4-bit unsigned increments. The block adds these increments up one at a time as the profile plays. Once it has used the chosen number of increments, it takes them back off in reverse order. This traces a triangle that repeats and returns to the starting value.

The block advances only on cycles where the phase-detector enable is high. It takes one step per programmed number of such cycles. A step period of zero switches modulation off and pins the output to the starting value. Two option bits post-process the word. One doubles the word. The other flips its least significant bit with a pseudo-random sequence. The output word is registered.

Top module: `ssc_profile_seq`

## Requirements
- R1: While `rst` is high, `ofs_out` is 0. Reset returns the step counter and the table index to zero and sets the profile to rising.
- R2: The first sample after reset is `start_ofs`, zero-extended.
- R3: On each rising step, the sample becomes the previous sample plus the next table entry. Entry i occupies bits [4i+3:4i] of `delta_tbl`, and entries are used in the order 0, 1, 2, ...
- R4: After the last used entry has been added, each further step subtracts the used entries in reverse order until the sample equals `start_ofs` again. The profile then rises again, giving a period of 2N steps for N used entries.
- R5: `samp_cnt` gives N, the number of entries used. With N = 0 the output stays at `start_ofs`. Values above 12 behave as 12.
- R6: With `step_per` = P > 0, one step happens every P cycles that have `pfd_en` high. The k-th step is visible on `ofs_out` after k·P + 1 enabled clock edges from reset release.
- R7: With `step_per` = 0, the output holds `start_ofs` and the counter and index stay cleared. Setting a non-zero period later starts the profile at its first step.
- R8: While `pfd_en` is low, the sample, the step counter and the dither source hold their values.
- R9: With `dbl_en` = 1, `ofs_out` is twice the current sample. The 10-bit word holds the largest case, 2·(63 + 12·15) = 486, without overflow.
- R10: With `dith_en` = 1, bit 0 of `ofs_out` is XORed with the output of a 15-bit maximal-length LFSR that never reaches zero. Bits above bit 0 are unaffected, and bit 0 takes both values over time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfd_en | input | 1 | Phase-detector-rate clock enable |
| start_ofs | input | 6 | Unsigned starting offset |
| delta_tbl | input | 48 | Twelve 4-bit unsigned increments, entry i at [4i+3:4i] |
| step_per | input | 4 | Enabled cycles per step; 0 turns spreading off |
| samp_cnt | input | 4 | Number of increments used |
| dith_en | input | 1 | LSB dither enable |
| dbl_en | input | 1 | Output doubling enable |
| ofs_out | output | 10 | Registered fractional offset word |

## Verification
The hardest event to reach from the ports is the turn at the top of the triangle followed by the full walk back down. Its timing depends on three things together: the step period, the number of increments used, and the one-cycle output register. The stimulus reaches it by resetting the block with a chosen configuration and then waiting an exact k·P + 1 edges for a chosen step k. Those values of k are placed just past the peak, at the bottom, and into the second period. A clamped count of 15 and an all-maximum table are used to reach the deepest descent and the widest word.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ssc_dir_e;
endpackage

// File: rtl/ssc_step_timer.sv
module ssc_step_timer #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic [PER_W-1:0] per,
  output logic             tick
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] last;

  assign last = per - PER_W'(1);
  assign tick = run && en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (en) begin
      if (cnt == last) cnt <= '0;
      else             cnt <= cnt + PER_W'(1);
    end
  end

  // R7: disabled spreading keeps the counter cleared
  a_r7_idle_cnt: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
  // R8: no enable, no count
  a_r8_timer_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !en) |=> $stable(cnt));
endmodule

// File: rtl/ssc_walker.sv
module ssc_walker
  import ssc_pkg::*;
#(
  parameter int OFS_W = 6,
  parameter int DLT_W = 4,
  parameter int N_DLT = 12,
  parameter int ACC_W = 10,
  localparam int IDX_W = $clog2(N_DLT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   tick,
  input  logic [OFS_W-1:0]       start,
  input  logic [N_DLT*DLT_W-1:0] delta_tbl,
  input  logic [IDX_W-1:0]       n_used,
  output logic [ACC_W-1:0]       acc
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [DLT_W-1:0] dl [N_DLT];
  logic [IDX_W-1:0] idx, idx_inc, idx_dec;
  ssc_dir_e         dir;
  logic [DLT_W-1:0] d_up, d_dn;
  logic [ACC_W-1:0] start_ext;

  for (genvar g = 0; g < N_DLT; g++) begin : g_unpack
    assign dl[g] = delta_tbl[g*DLT_W +: DLT_W];
  end

  assign idx_inc   = idx + ONE;
  assign idx_dec   = idx - ONE;
  assign d_up      = (int'(idx) < N_DLT) ? dl[idx] : '0;
  assign d_dn      = (idx != '0 && int'(idx_dec) < N_DLT) ? dl[idx_dec] : '0;
  assign start_ext = ACC_W'(start);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc <= start_ext;
      idx <= '0;
      dir <= DIR_UP;
    end else if (tick && n_used != '0) begin
      if (dir == DIR_UP && idx < n_used) begin
        acc <= acc + ACC_W'(d_up);
        idx <= idx_inc;
        if (idx_inc == n_used) dir <= DIR_DOWN;
      end else if (idx != '0) begin
        acc <= acc - ACC_W'(d_dn);
        idx <= idx_dec;
        if (idx == ONE) dir <= DIR_UP;
      end else begin
        dir <= DIR_UP;
      end
    end
  end

  // R3: index never passes the table end
  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    int'(idx) <= N_DLT);
  // R6: sample moves only on a step
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(acc));
  // R7: spreading off pins the sample to the start value
  a_r7_off_start: assert property (@(posedge clk) disable iff (rst)
    !run |=> acc == ACC_W'($past(start)));
  // R4: at the bottom of the triangle the profile rises
  a_r4_bottom_rises: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |-> dir == DIR_UP);
endmodule

// File: rtl/ssc_dither_lfsr.sv
module ssc_dither_lfsr #(
  parameter int LFSR_W = 15,
  parameter int TAP_A  = LFSR_W - 1,
  parameter int TAP_B  = LFSR_W - 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bit_o
);
  logic [LFSR_W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst)     st <= LFSR_W'(1);
    else if (en) st <= {st[LFSR_W-2:0], st[TAP_A] ^ st[TAP_B]};
  end

  assign bit_o = st[0];

  // R10: the sequence never locks at zero
  a_r10_lfsr_live: assert property (@(posedge clk) disable iff (rst)
    st != '0);
  // R8: source frozen without enable
  a_r8_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(st));
endmodule

// File: rtl/ssc_profile_seq.sv
module ssc_profile_seq #(
  parameter int OFS_W     = 6,
  parameter int DLT_W     = 4,
  parameter int N_DLT     = 12,
  parameter int PER_W     = 4,
  parameter int CNT_SEL_W = 4,
  parameter int LFSR_W    = 15,
  parameter int ACC_W     = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pfd_en,
  input  logic [OFS_W-1:0]       start_ofs,
  input  logic [N_DLT*DLT_W-1:0] delta_tbl,
  input  logic [PER_W-1:0]       step_per,
  input  logic [CNT_SEL_W-1:0]   samp_cnt,
  input  logic                   dith_en,
  input  logic                   dbl_en,
  output logic [ACC_W-1:0]       ofs_out
);
  localparam int IDX_W = $clog2(N_DLT + 1);

  logic             run, tick, dbit;
  logic [IDX_W-1:0] n_used;
  logic [ACC_W-1:0] acc, scaled;

  assign run    = step_per != '0;
  assign n_used = (int'(samp_cnt) > N_DLT) ? IDX_W'(N_DLT) : IDX_W'(samp_cnt);

  ssc_step_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .en(pfd_en), .run(run), .per(step_per), .tick(tick)
  );

  ssc_walker #(
    .OFS_W(OFS_W), .DLT_W(DLT_W), .N_DLT(N_DLT), .ACC_W(ACC_W)
  ) u_walker (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .start(start_ofs),
    .delta_tbl(delta_tbl), .n_used(n_used), .acc(acc)
  );

  ssc_dither_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .en(pfd_en), .bit_o(dbit)
  );

  assign scaled = dbl_en ? {acc[ACC_W-2:0], 1'b0} : acc;

  always_ff @(posedge clk) begin
    if (rst) ofs_out <= '0;
    else     ofs_out <= {scaled[ACC_W-1:1], scaled[0] ^ (dith_en & dbit)};
  end

  // R9: the doubled sample always fits the word
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    acc[ACC_W-1] == 1'b0);
  // R9: doubling without dither yields an even word
  a_r9_dbl_even: assert property (@(posedge clk) disable iff (rst)
    (dbl_en && !dith_en) |=> ofs_out[0] == 1'b0);
  // R1: output cleared while reset is held
  a_r1_reset_out: assert property (@(posedge clk)
    rst |=> ofs_out == '0);
endmodule

// File: tb/ssc_profile_seq_tb.sv
module ssc_profile_seq_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        pfd_en = 1;
  logic [5:0]  start_ofs = '0;
  logic [47:0] delta_tbl = '0;
  logic [3:0]  step_per = '0;
  logic [3:0]  samp_cnt = '0;
  logic        dith_en = 0;
  logic        dbl_en = 0;
  logic [9:0]  ofs_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ssc_profile_seq u_dut (
    .clk(clk), .rst(rst), .pfd_en(pfd_en), .start_ofs(start_ofs),
    .delta_tbl(delta_tbl), .step_per(step_per), .samp_cnt(samp_cnt),
    .dith_en(dith_en), .dbl_en(dbl_en), .ofs_out(ofs_out)
  );

  // fields: start(6) per(4) n(4) dbl(1) k(8)
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {6'd10, 4'd1, 4'd4, 1'b0, 8'd0},   // R2 first sample
    {6'd10, 4'd1, 4'd4, 1'b0, 8'd3},   // R3 rising
    {6'd10, 4'd1, 4'd4, 1'b0, 8'd4},   // R3 peak
    {6'd10, 4'd1, 4'd4, 1'b0, 8'd6},   // R4 descending
    {6'd10, 4'd1, 4'd4, 1'b0, 8'd8},   // R4 back at start
    {6'd10, 4'd1, 4'd4, 1'b0, 8'd11},  // R4 second period
    {6'd5,  4'd3, 4'd5, 1'b0, 8'd2},   // R6 period 3
    {6'd5,  4'd3, 4'd5, 1'b0, 8'd7},   // R6 period 3 descent
    {6'd30, 4'd2, 4'd0, 1'b0, 8'd9},   // R5 zero count
    {6'd7,  4'd1, 4'd15,1'b0, 8'd12},  // R5 clamp peak
    {6'd7,  4'd1, 4'd15,1'b0, 8'd24},  // R5 clamp full period
    {6'd12, 4'd4, 4'd3, 1'b1, 8'd2},   // R9 doubling
    {6'd0,  4'd15,4'd2, 1'b0, 8'd1}    // R6 longest period
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      1, 2: return "R3";
      3, 4, 5: return "R4";
      6, 7, 12: return "R6";
      8, 9, 10: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic int model(int st, int n, int k, bit dbl, logic [47:0] t);
    int nn, pos, lim, s;
    nn = (n > 12) ? 12 : n;
    s = st;
    if (nn != 0) begin
      pos = k % (2 * nn);
      lim = (pos <= nn) ? pos : 2 * nn - pos;
      for (int i = 0; i < lim; i++) s += int'(t[4*i +: 4]);
    end
    return dbl ? 2 * s : s;
  endfunction

  function automatic logic [47:0] tbl_a();
    logic [47:0] t;
    for (int i = 0; i < 12; i++) t[4*i +: 4] = 4'((i * 5 + 3) % 16);
    return t;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(int st, int p, int n, bit dbl);
    @(negedge clk);
    rst = 1; start_ofs = 6'(st); step_per = 4'(p); samp_cnt = 4'(n);
    dbl_en = dbl; dith_en = 0; pfd_en = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int snap, bad, ones;
    delta_tbl = tbl_a();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(ofs_out), 0);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      int st, p, n, k; bit dbl;
      {st, p, n, dbl, k} = {26'd0, VEC[i][22:17], 28'd0, VEC[i][16:13],
                            28'd0, VEC[i][12:9], VEC[i][8], 24'd0, VEC[i][7:0]};
      restart(st, p, n, dbl);
      repeat (k * p + 1) @(posedge clk);
      @(negedge clk);
      chk(vec_tag(i), int'(ofs_out), model(st, n, k, dbl, delta_tbl));
    end

    // R9: widest word with an all-maximum table
    delta_tbl = '1;
    restart(63, 1, 12, 1);
    repeat (13) @(posedge clk);
    @(negedge clk);
    chk("R9", int'(ofs_out), 486);
    delta_tbl = tbl_a();

    // R7: spreading off, then turned on without reset
    restart(9, 0, 5, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R7", int'(ofs_out), 9);
    step_per = 4'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", int'(ofs_out), model(9, 5, 1, 0, delta_tbl));

    // R8: enable low freezes the profile
    repeat (2) @(posedge clk);
    @(negedge clk);
    pfd_en = 0;
    @(posedge clk);
    @(negedge clk);
    snap = int'(ofs_out);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R8", int'(ofs_out), snap);
    chk("R8", snap, model(9, 5, 2, 0, delta_tbl));
    pfd_en = 1;

    // R10: dither touches only bit 0 and toggles it
    restart(20, 0, 3, 0);
    dith_en = 1;
    bad = 0; ones = 0;
    for (int c = 0; c < 64; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (ofs_out[9:1] != 9'd10) bad++;
      if (ofs_out[0]) ones++;
    end
    chk("R10", bad, 0);
    chk("R10", int'(ones > 0 && ones < 64), 1);
    dith_en = 0;

    finish_run();
  end
endmodule